// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. The line is sampled by a clock-enable pulse that runs at sixteen times the bit rate. The receiver looks for a falling edge, confirms the start bit at the middle of the bit period, and then samples each later bit at its centre. Each character is written into a sixteen-entry queue together with its own framing and parity error flags, so that error information stays attached to the byte it describes when the host drains the queue.

Framing is set by four static configuration inputs: seven or eight data bits, an optional parity bit that is even or odd, and one or two stop bits. Alongside the stored flags, the block gives one-cycle indications of a break and of a character lost to overrun. It also shows the fill count, an empty/non-empty indication and a full flag. A request-to-send output, active low, is driven from the fill count and throttles the far-end transmitter before the queue runs out of room. The consumer pops the head entry with a single strobe. The oldest entry is always visible at the head outputs.

Top module: `uart_rx`

## Requirements
- R1: After synchronous reset, fill_count is 0 and data_ready, fifo_full, overrun_pulse, break_pulse and rts_n are all 0.
- R2: With eight data bits, the bits that follow the start bit are taken least significant first, and the complete byte appears at head_data. fill_count rises by one and data_ready becomes 1.
- R3: With seven data bits (cfg_eight_bits = 0), only seven bits are taken and stored in head_data[6:0], with head_data[7] = 0. Any parity bit comes after the seventh bit.
- R4: With parity enabled, head_parity_err is 1 when the data bits and the received parity bit do not give the selected parity. cfg_parity_odd = 0 selects even parity (the XOR of data and parity is 0) and 1 selects odd parity (the XOR is 1).
- R5: head_frame_err is 1 when the first stop bit is sampled low. With cfg_two_stop = 1, the second stop bit is never checked.
- R6: break_pulse is high for one cycle when a character arrives whose data bits, parity bit (if enabled) and first stop bit are all 0. That character is still stored, with head_frame_err = 1.
- R7: A low pulse on rx_line that is back high before the eighth sample tick after the falling edge does not start a character.
- R8: Entries leave the queue in arrival order. A pop of a non-empty queue lowers fill_count by one, fill_count never exceeds 16, and data_ready is 1 exactly when fill_count is not 0.
- R9: fifo_full is 1 when 16 entries are held. A character that completes while the queue is full is discarded, and overrun_pulse goes high for one cycle.
- R10: rts_n is 1 whenever fill_count is 14 or more and 0 whenever it is below 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_line | input | 1 | Serial line, idle high |
| cfg_eight_bits | input | 1 | 1: eight data bits, 0: seven |
| cfg_parity_en | input | 1 | 1: a parity bit follows the data |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | 1: two stop bits |
| pop | input | 1 | Remove the head entry |
| head_data | output | 8 | Oldest stored character |
| head_frame_err | output | 1 | Framing error flag of the head entry |
| head_parity_err | output | 1 | Parity error flag of the head entry |
| fill_count | output | 5 | Number of stored entries |
| data_ready | output | 1 | Queue is not empty |
| fifo_full | output | 1 | Queue holds 16 entries |
| overrun_pulse | output | 1 | One cycle: character dropped because the queue was full |
| break_pulse | output | 1 | One cycle: all-zero character received |
| rts_n | output | 1 | Request to send, active low |

## Verification
On every cycle, the assertions check the queue's bookkeeping at the ports: the fill count stays in range and changes by at most one per cycle, data_ready agrees with the count, an overrun is only reported after a full cycle, and the request-to-send output is high whenever the queue is full. Only the bench scenarios show the character-level behaviour: bit order, seven-bit packing, the parity and framing verdicts, the unchecked second stop bit, break detection, glitch rejection, in-order draining, and the exact count thresholds at which rts_n moves and an overrun drops a character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_err;
        logic       parity_err;
    } rx_char_t;

    typedef struct packed {
        logic eight_bits;
        logic parity_en;
        logic parity_odd;
        logic two_stop;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_STOP2
    } rx_state_t;

    // Aligns a right-shifted sample register to the character width.
    function automatic logic [7:0] align_data(input logic [7:0] shreg, input logic eight);
        return eight ? shreg : {1'b0, shreg[7:1]};
    endfunction

    // 1 when the data, parity bit and mode disagree.
    function automatic logic parity_bad(input logic [7:0] data, input logic pbit, input logic odd);
        return (^data) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= rst ? 1'b1 : din;
            end else begin : g_next
                always_ff @(posedge clk) chain[i] <= rst ? 1'b1 : chain[i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx,
    input  rx_cfg_t  cfg,
    output logic     char_valid,
    output rx_char_t char_out,
    output logic     brk
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam logic [TW-1:0] MID_T  = TW'(OVERSAMPLE / 2 - 1);
    localparam logic [TW-1:0] LAST_T = TW'(OVERSAMPLE - 1);

    rx_state_t     st;
    logic [TW-1:0] tcnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          pbit;
    logic [7:0]    data_w;
    logic          at_centre;

    assign data_w    = align_data(shreg, cfg.eight_bits);
    assign at_centre = tick && (tcnt == LAST_T);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            tcnt       <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            pbit       <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
            brk        <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            brk        <= 1'b0;
            if (tick && st != ST_IDLE && !(st == ST_START && tcnt == MID_T))
                tcnt <= at_centre ? '0 : tcnt + 1'b1;
            case (st)
                ST_IDLE: begin
                    if (!rx) begin
                        st   <= ST_START;
                        tcnt <= '0;
                    end
                end
                ST_START: begin
                    if (tick && tcnt == MID_T) begin
                        tcnt    <= '0;
                        bit_idx <= '0;
                        st      <= rx ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (at_centre) begin
                        shreg <= {rx, shreg[7:1]};
                        if (bit_idx == (cfg.eight_bits ? 3'd7 : 3'd6))
                            st <= cfg.parity_en ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (at_centre) begin
                        pbit <= rx;
                        st   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (at_centre) begin
                        char_valid          <= 1'b1;
                        char_out.data       <= data_w;
                        char_out.frame_err  <= !rx;
                        char_out.parity_err <= cfg.parity_en && parity_bad(data_w, pbit, cfg.parity_odd);
                        brk                 <= !rx && (data_w == 8'h00) && !(cfg.parity_en && pbit);
                        st                  <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
                    end
                end
                ST_STOP2: begin
                    if (at_centre) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_char_t                   din,
    input  logic                       pop,
    output rx_char_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (count != FULL_C);
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
        end else begin
            ovr <= push && (count == FULL_C);
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_rx_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int RTS_LEVEL  = 14,
    parameter int OVERSAMPLE = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_tick,
    input  logic          rx_line,
    input  logic          cfg_eight_bits,
    input  logic          cfg_parity_en,
    input  logic          cfg_parity_odd,
    input  logic          cfg_two_stop,
    input  logic          pop,
    output logic [7:0]    head_data,
    output logic          head_frame_err,
    output logic          head_parity_err,
    output logic [CW-1:0] fill_count,
    output logic          data_ready,
    output logic          fifo_full,
    output logic          overrun_pulse,
    output logic          break_pulse,
    output logic          rts_n
);
    rx_cfg_t  cfg;
    rx_char_t new_char, head;
    logic     rx_s, char_valid;

    assign cfg = '{eight_bits: cfg_eight_bits, parity_en: cfg_parity_en,
                   parity_odd: cfg_parity_odd, two_stop: cfg_two_stop};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .din(rx_line), .dout(rx_s)
    );

    uart_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) framer_i (
        .clk(clk), .rst(rst), .tick(sample_tick), .rx(rx_s), .cfg(cfg),
        .char_valid(char_valid), .char_out(new_char), .brk(break_pulse)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .push(char_valid), .din(new_char), .pop(pop),
        .head(head), .count(fill_count), .ovr(overrun_pulse)
    );

    assign head_data       = head.data;
    assign head_frame_err  = head.frame_err;
    assign head_parity_err = head.parity_err;
    assign data_ready      = (fill_count != '0);
    assign fifo_full       = (fill_count == CW'(DEPTH));
    assign rts_n           = (fill_count >= CW'(RTS_LEVEL));
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] fill_count,
    input logic          data_ready,
    input logic          fifo_full,
    input logic          overrun_pulse,
    input logic          rts_n
);
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CW'(DEPTH));

    // R8
    ready_match_chk: assert property (@(posedge clk) disable iff (rst)
        data_ready == (fill_count != '0));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fill_count == $past(fill_count)) ||
                 (fill_count == $past(fill_count) + 1'b1) ||
                 (fill_count == $past(fill_count) - 1'b1));

    // R9
    ovr_after_full_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_pulse |-> $past(fifo_full));

    // R10
    rts_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> rts_n);
endmodule

bind uart_rx uart_rx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .fill_count(fill_count), .data_ready(data_ready),
    .fifo_full(fifo_full), .overrun_pulse(overrun_pulse), .rts_n(rts_n)
);

// File: tb/uart_rx_tb_top.sv
module uart_rx_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_line = 1'b1;
    logic eight = 1'b1, pen = 1'b0, podd = 1'b0, two = 1'b0;
    logic pop = 1'b0;
    logic [7:0] head_data;
    logic head_fe, head_pe, ready, full, ovr, brk, rts_n;
    logic [4:0] count;

    int checks = 0;
    int fails = 0;
    int brk_seen = 0;
    int ovr_seen = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_rx dut_i (
        .clk(clk), .rst(rst), .sample_tick(1'b1), .rx_line(rx_line),
        .cfg_eight_bits(eight), .cfg_parity_en(pen), .cfg_parity_odd(podd),
        .cfg_two_stop(two), .pop(pop), .head_data(head_data),
        .head_frame_err(head_fe), .head_parity_err(head_pe), .fill_count(count),
        .data_ready(ready), .fifo_full(full), .overrun_pulse(ovr),
        .break_pulse(brk), .rts_n(rts_n)
    );

    always @(posedge clk) begin
        if (!rst && brk) brk_seen++;
        if (!rst && ovr) ovr_seen++;
    end

    // {data, eight, pen, podd, two, bad_parity, stop1, stop2, exp_data, exp_fe, exp_pe}
    localparam logic [24:0] VEC [0:8] = '{
        {8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},  // R2
        {8'hC5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h45, 1'b0, 1'b0},  // R3
        {8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0},  // R4
        {8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b1},  // R4
        {8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0},  // R4
        {8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 1'b0, 1'b1},  // R4
        {8'h81, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1, 1'b0},  // R5
        {8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0},  // R5
        {8'h33, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h33, 1'b0, 1'b0}   // R3
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        rx_line = v;
        repeat (16) @(negedge clk);
    endtask

    // Sends one character with the current configuration.
    task automatic send(input logic [7:0] d, input logic bad, input logic s1, input logic s2);
        int n;
        logic p;
        n = eight ? 8 : 7;
        p = 1'b0;
        line_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            line_bit(d[i]);
            p = p ^ d[i];
        end
        if (pen) line_bit(p ^ podd ^ bad);
        line_bit(s1);
        if (two) line_bit(s2);
        line_bit(1'b1);
        repeat (8) @(negedge clk);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "count", count, 0);
        check("R1", "ready", ready, 0);
        check("R1", "full", full, 0);
        check("R1", "rts_n", rts_n, 0);
        check("R1", "pulses", {ovr, brk}, 0);

        // Vector walk: R2 R3 R4 R5
        for (int v = 0; v < 9; v++) begin
            logic [24:0] e;
            e = VEC[v];
            eight = e[16]; pen = e[15]; podd = e[14]; two = e[13];
            send(e[24:17], e[12], e[11], e[10]);
            check("R2", "count after char", count, 1);
            check("R2", "ready", ready, 1);
            check(v == 1 || v == 8 ? "R3" : "R2", "data", head_data, e[9:2]);
            check("R5", "frame_err", head_fe, e[1]);
            check("R4", "parity_err", head_pe, e[0]);
            do_pop();
            check("R8", "count after pop", count, 0);
        end
        check("R6", "no break from vectors", brk_seen, 0);

        // R6 break, 8N1
        eight = 1'b1; pen = 1'b0; podd = 1'b0; two = 1'b0;
        send(8'h00, 1'b0, 1'b0, 1'b1);
        check("R6", "break pulses", brk_seen, 1);
        check("R6", "stored", count, 1);
        check("R6", "break frame_err", head_fe, 1);
        check("R6", "break data", head_data, 0);
        do_pop();
        // R6 odd parity makes the parity bit 1: not a break
        pen = 1'b1; podd = 1'b1;
        send(8'h00, 1'b0, 1'b0, 1'b1);
        check("R6", "no break with parity one", brk_seen, 1);
        check("R5", "frame_err odd zero", head_fe, 1);
        do_pop();
        pen = 1'b0; podd = 1'b0;

        // R7 short glitch
        rx_line = 1'b0;
        repeat (5) @(negedge clk);
        rx_line = 1'b1;
        repeat (60) @(negedge clk);
        check("R7", "glitch count", count, 0);

        // R8 R9 R10 fill
        for (int k = 0; k < 16; k++) begin
            send(8'h10 + 8'(k), 1'b0, 1'b1, 1'b1);
            check("R8", "fill count", count, k + 1);
            if (k == 12) check("R10", "rts at 13", rts_n, 0);
            if (k == 13) check("R10", "rts at 14", rts_n, 1);
        end
        check("R9", "full", full, 1);
        send(8'hEE, 1'b0, 1'b1, 1'b1);
        check("R9", "overrun pulses", ovr_seen, 1);
        check("R9", "count stays", count, 16);
        for (int k = 0; k < 16; k++) begin
            check("R8", "order", head_data, 8'h10 + 8'(k));
            do_pop();
            if (k == 0) check("R10", "rts at 15", rts_n, 1);
            if (k == 0) check("R9", "not full at 15", full, 0);
            if (k == 2) check("R10", "rts at 13 drain", rts_n, 0);
        end
        check("R9", "dropped char absent", count, 0);
        check("R8", "ready empty", ready, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule